// File: doc/BRIEF.md
# Bus-Snooping Control-Flow Signature Watchdog

This block sits beside an unmodified processor on its shared bus and checks that program control moves between basic blocks along legal paths. It has no register the processor reads. Instrumented code announces each basic block with plain bus writes, and the block reacts to them. A write to the test address asks whether the running signature is acceptable for the block named in the write data. A write to the set address advances the running signature for that block. Writes into a small table window load the two mask values that belong to each block. A failed test raises a single mismatch flag. The flag stays high until reset.

Inside, a decoder state machine watches the bus and has three states. `ST_IDLE` means no request is pending. `ST_TEST` is the cycle in which a compare is enabled. `ST_SET` is the cycle in which the signature is advanced. Every state moves on the next clock according to the current bus cycle, so all states share one set of transitions. A test write goes to `ST_TEST`, a set write goes to `ST_SET`, and anything else returns to `ST_IDLE`. A separate signature store holds the mask pairs and has a registered read port, which is indexed by the block identifier in the write data. A consistency unit compares the running signature against the pair whenever the compare enable is high, and it latches any failure.

Top module: `cfw_watchdog`

## Requirements
- R1: After reset the mismatch output is 0, the running signature equals ENTRY_SIG (0x5A by default), and every stored mask value is 0.
- R2: A data write (bus_we=1, bus_instr=0) to address TBL_BASE + 2*b + s stores bus_wdata as mask M1 of block b when s=0, or as mask M2 of block b when s=1. TBL_BASE is 0x0100 by default.
- R3: A test request is a data write to TEST_ADDR (0x0200). It passes, leaving mismatch unchanged, when the running signature equals M1 of the named block.
- R4: A test request also passes when the running signature equals M2 of the named block.
- R5: A test request whose signature matches neither mask sets mismatch. The flag is still 0 one clock edge after the write is sampled, and it reads 1 from the second edge on.
- R6: A set request is a data write to SET_ADDR (0x0204). It replaces the running signature with (signature XOR M1) XOR M2 of the named block, and that value takes effect on the second edge after the write is sampled.
- R7: Once set, mismatch stays 1 regardless of later passing tests, until reset.
- R8: Bus cycles with bus_we=0, cycles flagged as instruction traffic (bus_instr=1), and writes to any other address change neither the signature nor the table.
- R9: Requests on consecutive cycles are each handled. A test issued on the cycle right after a set sees the updated signature.
- R10: For test and set requests, only the low log2(NBLK) bits of bus_wdata select the block (4 bits by default). The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_instr | input | 1 | 1 marks the cycle as instruction traffic, which is ignored |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | SIG_W | Bus write data: block identifier or mask value |
| mismatch | output | 1 | Sticky control-flow error flag |

## Verification
The legal path is tried in three ways: a test that matches M1, a test that matches M2 after a set has moved the signature, and a test on a second block whose M1 equals the updated signature. Together these tell the M1 and M2 comparisons apart from each other and from the XOR update.

Decoy traffic aims at the set and table addresses using reads, instruction-tagged writes and near-miss addresses. A later passing test then shows that none of this traffic took effect. Set and test requests on back-to-back cycles expose any hazard in the signature update. A deliberately failing test is sampled at both edges around its latency, which exercises the flag timing and its stickiness.

After a mid-run reset, a reloaded entry-value test must pass, and a test against a block that is no longer loaded must fail. Together these separate signature reset from table reset.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TEST = 2'd1,
        ST_SET  = 2'd2
    } cfw_state_e;
endpackage

// File: rtl/cfw_bus_if.sv
module cfw_bus_if
    import cfw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIG_W  = 8,
    parameter int IDX_W  = 4,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 16'h0200,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h0204,
    parameter logic [ADDR_W-1:0] TBL_BASE  = 16'h0100,
    parameter logic [SIG_W-1:0]  ENTRY_SIG = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_instr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIG_W-1:0]  bus_wdata,
    input  logic [SIG_W-1:0]  rd_m1,
    input  logic [SIG_W-1:0]  rd_m2,
    output logic              tbl_we,
    output logic              tbl_sel,
    output logic [IDX_W-1:0]  tbl_widx,
    output logic [SIG_W-1:0]  tbl_wval,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              cmp_en,
    output logic [SIG_W-1:0]  op_sig
);
    localparam int TAG_LSB = IDX_W + 1;

    cfw_state_e state_q, state_d;
    logic       wr_ok, hit_test, hit_set, hit_tbl, set_en;
    logic [SIG_W-1:0] sig_q;

    // bus decode
    always_comb begin
        wr_ok    = bus_we && !bus_instr;
        hit_test = wr_ok && (bus_addr == TEST_ADDR);
        hit_set  = wr_ok && (bus_addr == SET_ADDR);
        hit_tbl  = wr_ok && (bus_addr[ADDR_W-1:TAG_LSB] == TBL_BASE[ADDR_W-1:TAG_LSB]);
        tbl_we   = hit_tbl;
        tbl_sel  = bus_addr[0];
        tbl_widx = bus_addr[IDX_W:1];
        tbl_wval = bus_wdata;
        rd_idx   = bus_wdata[IDX_W-1:0];
    end

    // next state: identical from every state
    always_comb begin
        if (hit_test)
            state_d = ST_TEST;
        else if (hit_set)
            state_d = ST_SET;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        cmp_en = 1'b0;
        set_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_TEST: cmp_en = 1'b1;
            ST_SET:  set_en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sig_q <= ENTRY_SIG;
        else if (set_en)
            sig_q <= (sig_q ^ rd_m1) ^ rd_m2;
    end

    assign op_sig = sig_q;
endmodule

// File: rtl/cfw_sig_store.sv
module cfw_sig_store #(
    parameter int SIG_W = 8,
    parameter int NBLK  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [IDX_W-1:0] widx,
    input  logic [SIG_W-1:0] wval,
    input  logic [IDX_W-1:0] ridx,
    output logic [SIG_W-1:0] rd_m1,
    output logic [SIG_W-1:0] rd_m2
);
    logic [SIG_W-1:0] m1_q [NBLK];
    logic [SIG_W-1:0] m2_q [NBLK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                m1_q[i] <= '0;
                m2_q[i] <= '0;
            end
        end else if (we) begin
            if (sel)
                m2_q[widx] <= wval;
            else
                m1_q[widx] <= wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_m1 <= '0;
            rd_m2 <= '0;
        end else begin
            rd_m1 <= m1_q[ridx];
            rd_m2 <= m2_q[ridx];
        end
    end
endmodule

// File: rtl/cfw_check.sv
module cfw_check #(
    parameter int SIG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_en,
    input  logic [SIG_W-1:0] op_sig,
    input  logic [SIG_W-1:0] ok_a,
    input  logic [SIG_W-1:0] ok_b,
    output logic             mismatch
);
    logic bad;

    always_comb bad = cmp_en && (op_sig != ok_a) && (op_sig != ok_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mismatch <= 1'b0;
        else if (bad)
            mismatch <= 1'b1;
    end
endmodule

// File: rtl/cfw_watchdog.sv
module cfw_watchdog #(
    parameter int ADDR_W = 16,
    parameter int SIG_W  = 8,
    parameter int NBLK   = 16,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 16'h0200,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h0204,
    parameter logic [ADDR_W-1:0] TBL_BASE  = 16'h0100,
    parameter logic [SIG_W-1:0]  ENTRY_SIG = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_instr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIG_W-1:0]  bus_wdata,
    output logic              mismatch
);
    localparam int IDX_W = $clog2(NBLK);

    logic             tbl_we, tbl_sel, cmp_en;
    logic [IDX_W-1:0] tbl_widx, rd_idx;
    logic [SIG_W-1:0] tbl_wval, rd_m1, rd_m2, sig_q;

    cfw_bus_if #(
        .ADDR_W(ADDR_W), .SIG_W(SIG_W), .IDX_W(IDX_W),
        .TEST_ADDR(TEST_ADDR), .SET_ADDR(SET_ADDR),
        .TBL_BASE(TBL_BASE), .ENTRY_SIG(ENTRY_SIG)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_instr(bus_instr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_m1(rd_m1), .rd_m2(rd_m2),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_widx(tbl_widx), .tbl_wval(tbl_wval),
        .rd_idx(rd_idx), .cmp_en(cmp_en), .op_sig(sig_q)
    );

    cfw_sig_store #(.SIG_W(SIG_W), .NBLK(NBLK), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .sel(tbl_sel),
        .widx(tbl_widx), .wval(tbl_wval), .ridx(rd_idx),
        .rd_m1(rd_m1), .rd_m2(rd_m2)
    );

    cfw_check #(.SIG_W(SIG_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .op_sig(sig_q),
        .ok_a(rd_m1), .ok_b(rd_m2), .mismatch(mismatch)
    );
endmodule

// File: rtl/cfw_watchdog_sva.sv
module cfw_watchdog_sva #(
    parameter int ADDR_W = 16,
    parameter int SIG_W  = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 16'h0200,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h0204
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_instr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              mismatch,
    input logic              cmp_en,
    input logic [SIG_W-1:0]  sig_q
);
    logic test_req, set_req;
    assign test_req = bus_we && !bus_instr && (bus_addr == TEST_ADDR);
    assign set_req  = bus_we && !bus_instr && (bus_addr == SET_ADDR);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> mismatch); // R7
    AST_FLAG_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch) |-> $past(cmp_en)); // R5
    AST_CMP_FROM_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> $past(test_req)); // R3
    AST_SIG_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(set_req, 2) |-> $stable(sig_q)); // R8
endmodule

bind cfw_watchdog cfw_watchdog_sva #(
    .ADDR_W(ADDR_W), .SIG_W(SIG_W), .TEST_ADDR(TEST_ADDR), .SET_ADDR(SET_ADDR)
) u_sva (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_instr(bus_instr),
    .bus_addr(bus_addr), .mismatch(mismatch), .cmp_en(cmp_en), .sig_q(sig_q)
);

// File: tb/sim_cfw_watchdog.sv
module sim_cfw_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_TEST = 16'h0200;
    localparam logic [15:0] A_SET  = 16'h0204;
    localparam logic [15:0] A_TBL  = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_instr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        mismatch;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    cfw_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_instr(bus_instr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mismatch(mismatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [7:0] tm1 [16];
    logic [7:0] tm2 [16];
    logic [7:0] msig, pm1, pm2;
    bit         mmis, pend_test, pend_set;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin tm1[i] = 0; tm2[i] = 0; end
            msig = 8'h5A; mmis = 0; pend_test = 0; pend_set = 0;
        end else begin
            if (pend_test && msig != pm1 && msig != pm2) mmis = 1;
            if (pend_set) msig = msig ^ pm1 ^ pm2;
            pend_test = 0; pend_set = 0;
            if (bus_we && !bus_instr) begin
                if (bus_addr == A_TEST || bus_addr == A_SET) begin
                    pm1 = tm1[bus_wdata[3:0]];
                    pm2 = tm2[bus_wdata[3:0]];
                    if (bus_addr == A_TEST) pend_test = 1; else pend_set = 1;
                end else if (bus_addr >= A_TBL && bus_addr < A_TBL + 32) begin
                    if (bus_addr[0]) tm2[bus_addr[4:1]] = bus_wdata;
                    else             tm1[bus_addr[4:1]] = bus_wdata;
                end
            end
        end
    end

    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: mismatch=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) if (rst_n && !done) check(mismatch, mmis, "R5 R7 model");

    task automatic op(input bit we, input bit ins, input logic [15:0] a, input logic [7:0] d);
        bus_we = we; bus_instr = ins; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_instr = 0;
    endtask

    task automatic load(input int b, input logic [7:0] v1, input logic [7:0] v2);
        op(1, 0, A_TBL + 16'(2*b), v1);
        op(1, 0, A_TBL + 16'(2*b + 1), v2);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: cycles=%0d expected<=20000", cycles);
            report();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check(mismatch, 0, "R1 reset");
        load(1, 8'h5A, 8'h3C);                       // R2
        op(1, 0, A_TEST, 8'h01); idle(2);
        check(mismatch, 0, "R3 pass on M1");
        op(1, 0, A_SET, 8'h01); idle(2);              // R6: sig = 0x3C
        op(1, 0, A_TEST, 8'h01); idle(2);
        check(mismatch, 0, "R4 pass on M2");
        load(2, 8'h3C, 8'h00);
        op(1, 0, A_TEST, 8'h02); idle(2);
        check(mismatch, 0, "R6 updated signature");
        // R8 decoys
        op(1, 1, A_SET, 8'h01);
        op(0, 0, A_SET, 8'h01);
        op(0, 0, A_TBL + 16'd4, 8'hFF);
        op(1, 1, A_TBL + 16'd4, 8'hFF);
        op(1, 0, 16'h0203, 8'h01);
        op(1, 0, 16'h0205, 8'h01);
        idle(2);
        op(1, 0, A_TEST, 8'h02); idle(2);
        check(mismatch, 0, "R8 decoys ignored");
        op(1, 0, A_TEST, 8'hF2); idle(2);
        check(mismatch, 0, "R10 upper data bits ignored");
        // R9 back-to-back
        load(3, 8'h3C, 8'h99);
        load(4, 8'h99, 8'h11);
        op(1, 0, A_SET, 8'h03);                       // sig = 0x99
        op(1, 0, A_TEST, 8'h04);
        op(1, 0, A_SET, 8'h04);                       // sig = 0x11
        op(1, 0, A_TEST, 8'h04);
        idle(2);
        check(mismatch, 0, "R9 back-to-back");
        // R5 failing test and latency
        op(1, 0, A_TEST, 8'h05);
        check(mismatch, 0, "R5 not yet at first edge");
        idle(1);
        check(mismatch, 1, "R5 flag after second edge");
        op(1, 0, A_TEST, 8'h04); idle(4);
        check(mismatch, 1, "R7 sticky");
        // mid-run reset
        rst_n = 1'b0; idle(2);
        check(mismatch, 0, "R1 reset clears flag");
        rst_n = 1'b1; idle(1);
        load(6, 8'h5A, 8'h00);
        op(1, 0, A_TEST, 8'h06); idle(2);
        check(mismatch, 0, "R1 signature back to entry value");
        op(1, 0, A_TEST, 8'h01); idle(2);
        check(mismatch, 1, "R1 table cleared");
        idle(2);
        report();
    end
endmodule